// File: doc/BRIEF.md
# CAN receive acceptance filter

This block decides which of sixteen receive message slots, if any, stores an incoming CAN frame. For every frame offered with a one-cycle valid strobe, each slot compares the received 29-bit identifier with its own programmed identifier. Bits whose mask bit is clear are ignored in that comparison. A slot takes part only when its receive request is set and its programmed frame type (standard or extended) equals the type of the received frame.

Three mask registers exist. One group mask serves slots 0 to 13, and slots 14 and 15 each have a private mask. Masks are written through a small write port. A write is refused while any slot served by the target mask has a receive request. When several slots match, the lowest-numbered one wins. The winner appears one clock later as a one-hot vector and a binary index, together with a one-cycle store strobe. A frame that matches no slot raises a one-cycle ignore strobe instead.

Top module: `can_acf_top`

## Requirements
- R1: A slot can match only when its receive-request bit is 1 and its frame-type bit equals `frame_ext` (0 = standard, 1 = extended). A slot that fails either condition never matches, whatever the identifiers hold.
- R2: Slots 0 to 13 compare under the group mask, slot 14 under local mask A and slot 15 under local mask B. The write selector `mask_wr_sel` is encoded 0 = group mask, 1 = mask A, 2 = mask B, 3 = no register.
- R3: For each identifier bit, a mask bit of 0 makes that bit count as matching. A mask bit of 1 requires the received bit to equal the slot's programmed bit.
- R4: Identifiers are 29 bits wide. Bits [28:18] hold the 11 standard bits and bits [17:0] hold the 18 extended bits. An extended frame compares all 29 bits. A standard frame compares only bits [28:18], so for it bits [17:0] of both the slot and the frame have no effect.
- R5: When more than one slot matches, only the lowest-numbered matching slot is selected. Its bit alone is set in `hit_onehot`, and `hit_idx` carries its number in binary.
- R6: When no slot matches a valid frame, `ignore` is 1 for one cycle. In that cycle `store` is 0, `hit_onehot` is all zero and `hit_idx` is 0.
- R7: The result appears in the cycle after the clock edge that samples `frame_valid` high, and it lasts one cycle. In any cycle that follows an edge with `frame_valid` low, `store`, `ignore` and `hit_onehot` are all 0.
- R8: A mask write is refused in each of these cases: the group mask while any of slots 0 to 13 has a receive request, mask A while slot 14 has one, mask B while slot 15 has one, or selector value 3. A refused write leaves every mask unchanged and raises `mask_err` for one cycle after the write edge. An accepted write takes effect from that edge on, and `mask_err` stays 0.
- R9: Synchronous active-high reset sets all three masks to all ones (full compare) and drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe offering a received frame |
| frame_id | input | 29 | Received identifier, standard bits in [28:18] |
| frame_ext | input | 1 | Received frame type, 1 = extended |
| slot_ids | input | 464 | Programmed identifiers, slot j at [29*j +: 29] |
| slot_ext | input | 16 | Programmed frame type per slot, 1 = extended |
| slot_req | input | 16 | Receive request per slot |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_sel | input | 2 | Mask target: 0 group, 1 local A, 2 local B, 3 none |
| mask_wr_data | input | 29 | Mask value to write |
| hit_onehot | output | 16 | One-hot selected slot |
| hit_idx | output | 4 | Binary number of the selected slot |
| store | output | 1 | One-cycle strobe: frame goes to the selected slot |
| ignore | output | 1 | One-cycle strobe: frame matched no slot |
| mask_err | output | 1 | One-cycle flag for a refused mask write |

## Verification
A wrong mask bit appears only when a frame differs from a slot in that very bit. The bench therefore checks after every mask write by sending frames that differ from slot identifiers in a few bits. A stale or wrong mask shows up one cycle later as a wrong slot choice or a wrong store or ignore strobe.

A priority or grouping fault appears only when several slots carry related identifiers. The random slots are therefore drawn as small variations of one base identifier, so that frames often match more than one slot. A refused write that still changed a mask appears as a filtering difference on the next frame, on top of the `mask_err` check made in the cycle after the write.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;
    localparam int NUM_SLOTS  = 16;
    localparam int SHARED_CNT = 14;
    localparam int SLOT_A     = 14;
    localparam int SLOT_B     = 15;
    localparam int STD_W      = 11;
    localparam int EXT_W      = 18;
    localparam int ID_W       = STD_W + EXT_W;
    localparam int IDX_W      = $clog2(NUM_SLOTS);

    typedef logic [ID_W-1:0]      id_t;
    typedef logic [IDX_W-1:0]     idx_t;
    typedef logic [NUM_SLOTS-1:0] slot_vec_t;

    typedef enum logic [1:0] {
        SEL_GROUP = 2'd0,
        SEL_A     = 2'd1,
        SEL_B     = 2'd2,
        SEL_NONE  = 2'd3
    } mask_sel_e;

    typedef struct packed {
        logic      any;
        idx_t      idx;
        slot_vec_t onehot;
    } pick_t;

    localparam id_t STD_ONLY = {{STD_W{1'b1}}, {EXT_W{1'b0}}};

    function automatic logic id_match(id_t rx, id_t prog, id_t mask, logic ext);
        id_t diff;
        diff = (rx ^ prog) & mask;
        if (!ext) diff = diff & STD_ONLY;
        return diff == '0;
    endfunction
endpackage

// File: rtl/can_acf_mask_bank.sv
module can_acf_mask_bank
    import can_acf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic [1:0] wr_sel,
    input  id_t       wr_data,
    input  slot_vec_t slot_req,
    output id_t       mask_g,
    output id_t       mask_a,
    output id_t       mask_b,
    output logic      wr_err
);
    mask_sel_e sel;
    logic busy_g, busy_a, busy_b, refuse;

    always_comb begin
        sel    = mask_sel_e'(wr_sel);
        busy_g = |slot_req[SHARED_CNT-1:0];
        busy_a = slot_req[SLOT_A];
        busy_b = slot_req[SLOT_B];
        unique case (sel)
            SEL_GROUP: refuse = busy_g;
            SEL_A:     refuse = busy_a;
            SEL_B:     refuse = busy_b;
            default:   refuse = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_g <= '1;
            mask_a <= '1;
            mask_b <= '1;
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_en && refuse;
            if (wr_en && !refuse) begin
                if (sel == SEL_GROUP) mask_g <= wr_data;
                if (sel == SEL_A)     mask_a <= wr_data;
                if (sel == SEL_B)     mask_b <= wr_data;
            end
        end
    end

    assert_group_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && |slot_req[SHARED_CNT-1:0]) |=> ($stable(mask_g) && wr_err));
    assert_a_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && slot_req[SLOT_A]) |=> ($stable(mask_a) && wr_err));
    assert_b_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && slot_req[SLOT_B]) |=> ($stable(mask_b) && wr_err));
    assert_no_write_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(mask_g) && $stable(mask_a) && $stable(mask_b) && !wr_err));
endmodule

// File: rtl/can_acf_slot_cmp.sv
module can_acf_slot_cmp
    import can_acf_pkg::*;
(
    input  id_t                       frame_id,
    input  logic                      frame_ext,
    input  logic [NUM_SLOTS*ID_W-1:0] slot_ids,
    input  slot_vec_t                 slot_ext,
    input  slot_vec_t                 slot_req,
    input  id_t                       mask_g,
    input  id_t                       mask_a,
    input  id_t                       mask_b,
    output slot_vec_t                 match
);
    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_slot
        id_t slot_mask;
        if (j < SHARED_CNT) begin : g_grp
            assign slot_mask = mask_g;
        end else if (j == SLOT_A) begin : g_a
            assign slot_mask = mask_a;
        end else begin : g_b
            assign slot_mask = mask_b;
        end
        assign match[j] = slot_req[j] && (slot_ext[j] == frame_ext)
                       && id_match(frame_id, slot_ids[j*ID_W +: ID_W], slot_mask, frame_ext);
    end
endmodule

// File: rtl/can_acf_prio.sv
module can_acf_prio
    import can_acf_pkg::*;
(
    input  slot_vec_t match,
    output pick_t     pick
);
    always_comb begin
        pick = '0;
        for (int j = NUM_SLOTS - 1; j >= 0; j--) begin
            if (match[j]) begin
                pick.any    = 1'b1;
                pick.idx    = idx_t'(j);
                pick.onehot = slot_vec_t'(1) << j;
            end
        end
    end

    always_comb begin
        if (match != '0) begin
            assert_lowest_R5: assert (match[pick.idx] && ((match & (pick.onehot - 1'b1)) == '0));
        end
    end
endmodule

// File: rtl/can_acf_top.sv
module can_acf_top
    import can_acf_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      frame_valid,
    input  logic [ID_W-1:0]           frame_id,
    input  logic                      frame_ext,
    input  logic [NUM_SLOTS*ID_W-1:0] slot_ids,
    input  logic [NUM_SLOTS-1:0]      slot_ext,
    input  logic [NUM_SLOTS-1:0]      slot_req,
    input  logic                      mask_wr_en,
    input  logic [1:0]                mask_wr_sel,
    input  logic [ID_W-1:0]           mask_wr_data,
    output logic [NUM_SLOTS-1:0]      hit_onehot,
    output logic [IDX_W-1:0]          hit_idx,
    output logic                      store,
    output logic                      ignore,
    output logic                      mask_err
);
    id_t       mask_g, mask_a, mask_b;
    slot_vec_t match;
    pick_t     pick;

    can_acf_mask_bank u_masks (
        .clk(clk), .rst(rst), .wr_en(mask_wr_en), .wr_sel(mask_wr_sel),
        .wr_data(mask_wr_data), .slot_req(slot_req),
        .mask_g(mask_g), .mask_a(mask_a), .mask_b(mask_b), .wr_err(mask_err)
    );

    can_acf_slot_cmp u_cmp (
        .frame_id(frame_id), .frame_ext(frame_ext), .slot_ids(slot_ids),
        .slot_ext(slot_ext), .slot_req(slot_req),
        .mask_g(mask_g), .mask_a(mask_a), .mask_b(mask_b), .match(match)
    );

    can_acf_prio u_prio (.match(match), .pick(pick));

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_onehot <= '0;
            hit_idx    <= '0;
            store      <= 1'b0;
            ignore     <= 1'b0;
        end else begin
            hit_onehot <= frame_valid ? pick.onehot : '0;
            hit_idx    <= (frame_valid && pick.any) ? pick.idx : '0;
            store      <= frame_valid && pick.any;
            ignore     <= frame_valid && !pick.any;
        end
    end

    assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_onehot));
    assert_idx_agrees_R5: assert property (@(posedge clk) disable iff (rst)
        store |-> hit_onehot[hit_idx]);
    assert_ignore_clean_R6: assert property (@(posedge clk) disable iff (rst)
        ignore |-> (!store && hit_onehot == '0 && hit_idx == '0));
    assert_answer_R7: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> (store != ignore));
    assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |=> (!store && !ignore && hit_onehot == '0));
endmodule

// File: tb/tb_can_acf_top.sv
module tb_can_acf_top;
    import can_acf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_valid = 1'b0;
    id_t  frame_id = '0;
    logic frame_ext = 1'b0;
    logic [NUM_SLOTS*ID_W-1:0] slot_ids;
    slot_vec_t slot_ext = '0;
    slot_vec_t slot_req = '0;
    logic mask_wr_en = 1'b0;
    logic [1:0] mask_wr_sel = 2'd0;
    id_t  mask_wr_data = '0;
    slot_vec_t hit_onehot;
    idx_t hit_idx;
    logic store, ignore, mask_err;

    id_t sid [NUM_SLOTS];
    id_t sh_g, sh_a, sh_b;
    int  n_chk = 0;
    int  n_bad = 0;

    always #5 clk = ~clk;

    always_comb
        for (int j = 0; j < NUM_SLOTS; j++) slot_ids[j*ID_W +: ID_W] = sid[j];

    can_acf_top dut (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_id(frame_id),
        .frame_ext(frame_ext), .slot_ids(slot_ids), .slot_ext(slot_ext),
        .slot_req(slot_req), .mask_wr_en(mask_wr_en), .mask_wr_sel(mask_wr_sel),
        .mask_wr_data(mask_wr_data), .hit_onehot(hit_onehot), .hit_idx(hit_idx),
        .store(store), .ignore(ignore), .mask_err(mask_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic slot_vec_t ref_oh(id_t rx, logic ext);
        id_t m, d;
        for (int j = 0; j < NUM_SLOTS; j++) begin
            m = (j < SHARED_CNT) ? sh_g : (j == SLOT_A) ? sh_a : sh_b;
            d = (rx ^ sid[j]) & m;
            if (!ext) d = d & {{STD_W{1'b1}}, {EXT_W{1'b0}}};
            if (slot_req[j] && slot_ext[j] == ext && d == '0)
                return slot_vec_t'(1) << j;
        end
        return '0;
    endfunction

    function automatic idx_t oh2idx(slot_vec_t v);
        for (int j = 0; j < NUM_SLOTS; j++) if (v[j]) return idx_t'(j);
        return '0;
    endfunction

    task automatic send(id_t id, logic ext, string tag);
        slot_vec_t e;
        @(negedge clk);
        frame_valid = 1'b1; frame_id = id; frame_ext = ext;
        e = ref_oh(id, ext);
        @(negedge clk);
        frame_valid = 1'b0;
        check(tag, {store, ignore, hit_idx, hit_onehot},
                   {e != '0, e == '0, oh2idx(e), e});
    endtask

    task automatic wr(logic [1:0] sel, id_t data, string tag);
        logic bad;
        bad = (sel == 2'd3) || (sel == 2'd0 && |slot_req[SHARED_CNT-1:0])
           || (sel == 2'd1 && slot_req[SLOT_A]) || (sel == 2'd2 && slot_req[SLOT_B]);
        @(negedge clk);
        mask_wr_en = 1'b1; mask_wr_sel = sel; mask_wr_data = data;
        @(negedge clk);
        mask_wr_en = 1'b0;
        check(tag, {31'd0, mask_err}, {31'd0, bad});
        if (!bad) begin
            if (sel == 2'd0) sh_g = data;
            if (sel == 2'd1) sh_a = data;
            if (sel == 2'd2) sh_b = data;
        end
    endtask

    task automatic set_req(slot_vec_t r);
        @(negedge clk);
        slot_req = r;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        id_t base;
        logic [31:0] r;
        void'($urandom(32'd4242));
        for (int j = 0; j < NUM_SLOTS; j++) sid[j] = id_t'(j * 32'h0013_5791);
        sh_g = '1; sh_a = '1; sh_b = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9 outputs after reset", {store, ignore, mask_err, hit_idx, hit_onehot}, '0);

        // R9: masks start as full compare
        slot_ext = '1;
        set_req(16'h0008);
        send(sid[3] ^ 29'h1, 1'b1, "R9 full mask after reset");
        check("R9 near id ignored", {31'd0, ignore}, 32'd1);
        send(sid[3], 1'b1, "R1 exact id stored");
        check("R1 slot 3 chosen", {28'd0, hit_idx}, 32'd3);
        @(negedge clk);
        check("R7 strobes last one cycle", {store, ignore, hit_onehot}, '0);

        // R1: receive request off
        set_req(16'h0000);
        send(sid[3], 1'b1, "R1 request off");
        check("R1 request off ignored", {31'd0, ignore}, 32'd1);

        // R3: don't-care bit
        wr(2'd0, ~29'h1, "R8 group write accepted");
        set_req(16'h0008);
        send(sid[3] ^ 29'h1, 1'b1, "R3 masked bit");
        check("R3 masked bit matches", {28'd0, store, hit_idx}, {28'd0, 1'b1, 4'd3});
        send(sid[3] ^ 29'h2, 1'b1, "R3 compared bit");
        check("R3 compared bit rejects", {31'd0, ignore}, 32'd1);

        // R8: refused writes
        wr(2'd0, '1, "R8 group write refused");
        send(sid[3] ^ 29'h1, 1'b1, "R8 group mask unchanged");
        check("R8 refused write kept mask", {31'd0, store}, 32'd1);
        set_req(16'h4000);
        wr(2'd1, '0, "R8 mask A refused");
        set_req(16'h8000);
        wr(2'd2, '0, "R8 mask B refused");
        wr(2'd3, '0, "R8 selector 3 refused");
        wr(2'd1, ~29'h4, "R8 mask A accepted");
        set_req(16'h0000);
        wr(2'd0, '1, "R8 group restore");

        // R2: slot 14 under mask A, slot 3 under group mask
        sid[14] = sid[3];
        set_req(16'h4008);
        send(sid[3] ^ 29'h4, 1'b1, "R2 mask A only for slot 14");
        check("R2 slot 14 chosen", {28'd0, hit_idx}, 32'd14);

        // R5: priority
        sid[2] = sid[3]; sid[5] = sid[3];
        set_req(16'h4024 | 16'h0008);
        send(sid[3], 1'b1, "R5 several matches");
        check("R5 lowest slot", {16'd0, hit_onehot}, 32'h0004);
        set_req(16'h4020);
        send(sid[3], 1'b1, "R5 next lowest");
        check("R5 slot 5 chosen", {28'd0, hit_idx}, 32'd5);

        // R1/R4: frame type
        slot_ext[5] = 1'b0;
        send(sid[3], 1'b1, "R1 type mismatch skips slot 5");
        check("R1 slot 14 wins", {28'd0, hit_idx}, 32'd14);
        send(sid[3] ^ 29'h3_FFFF, 1'b0, "R4 standard ignores low bits");
        check("R4 standard match", {28'd0, store, hit_idx}, {28'd0, 1'b1, 4'd5});
        send(sid[3] ^ 29'h4_0000, 1'b0, "R4 standard bit compared");
        check("R4 standard bit rejects", {31'd0, ignore}, 32'd1);
        send(sid[3] ^ 29'h3_FFFF, 1'b1, "R6 no match");
        check("R6 ignore strobe", {store, ignore, hit_idx, hit_onehot}, {1'b0, 1'b1, 4'd0, 16'd0});

        // random mix
        for (int it = 0; it < 600; it++) begin
            r = $urandom;
            base = r[ID_W-1:0];
            for (int j = 0; j < NUM_SLOTS; j++) begin
                r = $urandom;
                sid[j] = base ^ (r[3] ? id_t'(1) << r[8:4] : '0);
            end
            r = $urandom;
            slot_ext = r[15:0];
            r = $urandom;
            set_req(r[15:0] & $urandom);
            if (it % 4 == 0) begin
                r = $urandom;
                base = ~(id_t'(1) << r[12:8]) & ~(r[0] ? id_t'(1) << r[17:13] : '0);
                wr(r[31:30], base, "R8 random write");
            end
            r = $urandom;
            base = sid[r[3:0]] ^ (r[4] ? id_t'(1) << r[9:5] : '0);
            send(base, r[10], "R5 random frame");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule